// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits beside one processor and decides which single interrupt is presented to it. Interrupt sources send presentation requests, each carrying a 24-bit source number, an 8-bit priority and the identity of the sending source unit. The presenter accepts or refuses each request in the cycle it arrives. It keeps one pending slot and drives one interrupt line to the processor. Lower priority numbers are more favoured. A more favoured request displaces the one already pending, and the displaced interrupt goes back to the source unit that sent it.

Software works the presenter through a small operation port. It can take the pending interrupt, signal end-of-interrupt, change the current processor priority and set the priority of an inter-processor interrupt. The inter-processor interrupt competes for the same pending slot under the fixed source number 2. The pending word and the inter-processor priority can be read at any time without side effects. Displaced interrupts, end-of-interrupt notices and resend requests leave on single-cycle pulse ports toward the sources.

Top module: `intr_presenter`

## Requirements
- R1: After reset the pending word is 0x00000000, the inter-processor priority reads 0xFF, the interrupt line is low and no pulse output is active.
- R2: The pending word carries the current processor priority in bits 31:24 and the pending source number in bits 23:0. A source field of zero means nothing is pending. The interrupt line is high exactly when the source field is non-zero. With no operation and no request, the pending word and the inter-processor priority stay unchanged.
- R3: reqReject is asserted in the request cycle when the request priority is greater than or equal to the current priority, or when something is pending at a priority less than or equal to the request priority. A rejected request changes no state.
- R4: An accepted request loads its source number and priority into the pending slot and raises the line on the next cycle. If the displaced interrupt came from a source unit, dispValid pulses one cycle later with that interrupt's source number and unit. A displaced inter-processor interrupt is not reported.
- R5: swOp=1 (accept) shows the pending word during that cycle. It then sets the current priority to the old pending priority, clears the source field, lowers the line and returns the pending priority to 0xFF.
- R6: swOp=3 loads the current priority from swData[31:24]. If the new value is smaller than the old one, something is pending and the new value is less than or equal to the pending priority, then the pending interrupt is dropped: the source field is cleared, the line is lowered and the interrupt is reported on the displaced port when it came from a source unit.
- R7: swOp=3 with a value greater than or equal to the old current priority, while nothing is pending, pulses resendValid. In the same step the inter-processor interrupt is presented if its priority is below the new current priority.
- R8: swOp=4 loads the inter-processor priority from swData[7:0]. If that value is below the current priority, and nothing is pending at a priority less than or equal to it, source 2 is loaded at that priority and the line is raised.
- R9: swOp=2 (end-of-interrupt) loads the current priority from swData[31:24] and pulses eoiValid one cycle later with eoiSource = swData[23:0]. If nothing is pending it also resends, with the same inter-processor check as R7.
- R10: A request arriving in the same cycle as any software operation is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Presentation request strobe |
| reqSource | input | 24 | Source number of the request |
| reqPrio | input | 8 | Priority of the request |
| reqOwner | input | 4 | Source unit that sent the request |
| reqReject | output | 1 | Same-cycle refusal of the request |
| swOp | input | 3 | Software operation: 0 none, 1 accept, 2 end-of-interrupt, 3 set current priority, 4 set inter-processor priority |
| swData | input | 32 | Operand of the software operation |
| pendWord | output | 32 | Current priority and pending source |
| ipiPrio | output | 8 | Inter-processor priority |
| irqOut | output | 1 | Interrupt line to the processor |
| dispValid | output | 1 | Displaced-interrupt pulse |
| dispSource | output | 24 | Source number of the displaced interrupt |
| dispOwner | output | 4 | Source unit of the displaced interrupt |
| eoiValid | output | 1 | End-of-interrupt pulse |
| eoiSource | output | 24 | Completed source number |
| resendValid | output | 1 | Resend request pulse |

## Verification
The assertions check on every cycle that the line agrees with a non-zero source field, that a request no more favoured than the current priority is refused, that an accept empties the slot and that an end-of-interrupt produces its notice with the right source. Only the scenarios can show the finer ordering: which interrupt gets displaced and to which unit, the chained resend that presents the inter-processor interrupt, and the case where a lowered priority leaves a more favoured pending interrupt in place.

// File: rtl/intr_pres_pkg.sv
package intr_pres_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ACCEPT = 3'd1,
    OP_EOI    = 3'd2,
    OP_SETCUR = 3'd3,
    OP_SETIPI = 3'd4
  } sw_op_e;

  typedef struct packed {
    logic loadReq;
    logic loadIpi;
    logic clearPend;
    logic acceptMove;
    logic setCur;
    logic setIpi;
    logic rejectOld;
    logic sendEoi;
    logic sendResend;
  } strobe_t;

endpackage

// File: rtl/intr_pres_ctrl.sv
module intr_pres_ctrl
  import intr_pres_pkg::*;
#(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8,
  localparam int WORD_W = SRC_W + PRIO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        swOp,
  input  logic [WORD_W-1:0] swData,
  input  logic              reqValid,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic [PRIO_W-1:0] curPrio,
  input  logic [PRIO_W-1:0] pendPrio,
  input  logic [PRIO_W-1:0] ipiCur,
  input  logic              havePend,
  input  logic              ownerValid,
  output logic              reqReject,
  output strobe_t           stb
);

  sw_op_e op;
  logic [PRIO_W-1:0] newCur;
  logic [PRIO_W-1:0] newIpi;

  assign op     = sw_op_e'(swOp);
  assign newCur = swData[WORD_W-1 -: PRIO_W];
  assign newIpi = swData[PRIO_W-1:0];

  assign reqReject = reqValid &&
    ((op != OP_NONE) || (reqPrio >= curPrio) || (havePend && (pendPrio <= reqPrio)));

  always_comb begin
    stb = '0;
    unique case (op)
      OP_ACCEPT: begin
        stb.acceptMove = 1'b1;
        stb.clearPend  = 1'b1;
      end
      OP_SETCUR: begin
        stb.setCur = 1'b1;
        if (newCur < curPrio) begin
          if (havePend && (newCur <= pendPrio)) begin
            stb.clearPend = 1'b1;
            stb.rejectOld = ownerValid;
          end
        end else if (!havePend) begin
          stb.sendResend = 1'b1;
          stb.loadIpi    = (ipiCur < newCur);
        end
      end
      OP_SETIPI: begin
        stb.setIpi = 1'b1;
        if ((newIpi < curPrio) && !(havePend && (pendPrio <= newIpi))) begin
          stb.loadIpi   = 1'b1;
          stb.rejectOld = havePend && ownerValid;
        end
      end
      OP_EOI: begin
        stb.setCur  = 1'b1;
        stb.sendEoi = 1'b1;
        if (!havePend) begin
          stb.sendResend = 1'b1;
          stb.loadIpi    = (ipiCur < newCur);
        end
      end
      default: begin
        if (reqValid && !reqReject) begin
          stb.loadReq   = 1'b1;
          stb.rejectOld = havePend && ownerValid;
        end
      end
    endcase
  end

  // R3: a request that is not more favoured than the current priority is refused
  a_r3_unfavoured_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqPrio >= curPrio)) |-> reqReject);

  // R10: a software operation in the same cycle refuses the request
  a_r10_op_blocks_request: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (swOp != 3'd0)) |-> reqReject);

endmodule

// File: rtl/intr_pres_dp.sv
module intr_pres_dp
  import intr_pres_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int OWNER_W = 4,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = SRC_W + PRIO_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [WORD_W-1:0]  swData,
  input  logic [SRC_W-1:0]   reqSource,
  input  logic [PRIO_W-1:0]  reqPrio,
  input  logic [OWNER_W-1:0] reqOwner,
  output logic [PRIO_W-1:0]  curPrio,
  output logic [PRIO_W-1:0]  pendPrio,
  output logic [PRIO_W-1:0]  ipiCur,
  output logic               havePend,
  output logic               ownerValid,
  output logic [WORD_W-1:0]  pendWord,
  output logic               irqOut,
  output logic               dispValid,
  output logic [SRC_W-1:0]   dispSource,
  output logic [OWNER_W-1:0] dispOwner,
  output logic               eoiValid,
  output logic [SRC_W-1:0]   eoiSource,
  output logic               resendValid
);

  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

  logic [SRC_W-1:0]   srcReg;
  logic [OWNER_W-1:0] ownerReg;
  logic [PRIO_W-1:0]  ipiNext;

  assign ipiNext  = stb.setIpi ? swData[PRIO_W-1:0] : ipiCur;
  assign havePend = (srcReg != '0);
  assign pendWord = {curPrio, srcReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPrio     <= '0;
      srcReg      <= '0;
      pendPrio    <= PRIO_IDLE;
      ipiCur      <= PRIO_IDLE;
      ownerReg    <= '0;
      ownerValid  <= 1'b0;
      irqOut      <= 1'b0;
      dispValid   <= 1'b0;
      dispSource  <= '0;
      dispOwner   <= '0;
      eoiValid    <= 1'b0;
      eoiSource   <= '0;
      resendValid <= 1'b0;
    end else begin
      ipiCur <= ipiNext;
      if (stb.acceptMove)  curPrio <= pendPrio;
      else if (stb.setCur) curPrio <= swData[WORD_W-1 -: PRIO_W];

      if (stb.loadReq) begin
        srcReg     <= reqSource;
        pendPrio   <= reqPrio;
        ownerReg   <= reqOwner;
        ownerValid <= 1'b1;
        irqOut     <= 1'b1;
      end else if (stb.loadIpi) begin
        srcReg     <= SRC_W'(IPI_SRC);
        pendPrio   <= ipiNext;
        ownerValid <= 1'b0;
        irqOut     <= 1'b1;
      end else if (stb.clearPend) begin
        srcReg     <= '0;
        pendPrio   <= PRIO_IDLE;
        ownerValid <= 1'b0;
        irqOut     <= 1'b0;
      end

      dispValid <= stb.rejectOld;
      if (stb.rejectOld) begin
        dispSource <= srcReg;
        dispOwner  <= ownerReg;
      end
      eoiValid <= stb.sendEoi;
      if (stb.sendEoi) eoiSource <= swData[SRC_W-1:0];
      resendValid <= stb.sendResend;
    end
  end

  // R2: the line is high exactly when a source is pending
  a_r2_line_tracks_slot: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (srcReg != '0));

  // R4: a displaced report always names a real source
  a_r4_disp_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> (dispSource != '0));

endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
  import intr_pres_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int OWNER_W = 4,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = SRC_W + PRIO_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [SRC_W-1:0]   reqSource,
  input  logic [PRIO_W-1:0]  reqPrio,
  input  logic [OWNER_W-1:0] reqOwner,
  output logic               reqReject,
  input  logic [2:0]         swOp,
  input  logic [WORD_W-1:0]  swData,
  output logic [WORD_W-1:0]  pendWord,
  output logic [PRIO_W-1:0]  ipiPrio,
  output logic               irqOut,
  output logic               dispValid,
  output logic [SRC_W-1:0]   dispSource,
  output logic [OWNER_W-1:0] dispOwner,
  output logic               eoiValid,
  output logic [SRC_W-1:0]   eoiSource,
  output logic               resendValid
);

  strobe_t           stb;
  logic [PRIO_W-1:0] curPrio;
  logic [PRIO_W-1:0] pendPrio;
  logic              havePend;
  logic              ownerValid;

  intr_pres_ctrl #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .swOp(swOp), .swData(swData),
    .reqValid(reqValid), .reqPrio(reqPrio), .curPrio(curPrio),
    .pendPrio(pendPrio), .ipiCur(ipiPrio), .havePend(havePend),
    .ownerValid(ownerValid), .reqReject(reqReject), .stb(stb)
  );

  intr_pres_dp #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .OWNER_W(OWNER_W), .IPI_SRC(IPI_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .swData(swData),
    .reqSource(reqSource), .reqPrio(reqPrio), .reqOwner(reqOwner),
    .curPrio(curPrio), .pendPrio(pendPrio), .ipiCur(ipiPrio),
    .havePend(havePend), .ownerValid(ownerValid), .pendWord(pendWord),
    .irqOut(irqOut), .dispValid(dispValid), .dispSource(dispSource),
    .dispOwner(dispOwner), .eoiValid(eoiValid), .eoiSource(eoiSource),
    .resendValid(resendValid)
  );

  // R5: an accept leaves the slot empty and the line low
  a_r5_accept_empties: assert property (@(posedge clk) disable iff (!rstN)
    (swOp == 3'd1) |=> (!irqOut && (pendWord[SRC_W-1:0] == '0)));

  // R9: end-of-interrupt produces its notice with the written source
  a_r9_eoi_notice: assert property (@(posedge clk) disable iff (!rstN)
    (swOp == 3'd2) |=> (eoiValid && (eoiSource == $past(swData[SRC_W-1:0]))));

endmodule

// File: tb/tb_intr_presenter.sv
module tb_intr_presenter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] reqSource = '0;
  logic [7:0]  reqPrio = '0;
  logic [3:0]  reqOwner = '0;
  logic        reqReject;
  logic [2:0]  swOp = '0;
  logic [31:0] swData = '0;
  logic [31:0] pendWord;
  logic [7:0]  ipiPrio;
  logic        irqOut;
  logic        dispValid;
  logic [23:0] dispSource;
  logic [3:0]  dispOwner;
  logic        eoiValid;
  logic [23:0] eoiSource;
  logic        resendValid;

  int checks = 0;
  int errors = 0;
  logic combReject;
  logic [31:0] combWord;

  always #2 clk = ~clk;

  intr_presenter dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSource(reqSource),
    .reqPrio(reqPrio), .reqOwner(reqOwner), .reqReject(reqReject),
    .swOp(swOp), .swData(swData), .pendWord(pendWord), .ipiPrio(ipiPrio),
    .irqOut(irqOut), .dispValid(dispValid), .dispSource(dispSource),
    .dispOwner(dispOwner), .eoiValid(eoiValid), .eoiSource(eoiSource),
    .resendValid(resendValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle: capture combinational outputs before the edge, then
  // release inputs just after it, leaving registered outputs to be checked.
  task automatic step(input logic rv, input logic [23:0] rs, input logic [7:0] rp,
                      input logic [3:0] ro, input logic [2:0] op, input logic [31:0] d);
    @(negedge clk);
    reqValid = rv; reqSource = rs; reqPrio = rp; reqOwner = ro; swOp = op; swData = d;
    #1;
    combReject = reqReject;
    combWord   = pendWord;
    @(posedge clk);
    #1;
    reqValid = 1'b0; swOp = 3'd0;
  endtask

  task automatic t_reset;
    check("R1 pendWord", pendWord, 32'h0);
    check("R1 ipiPrio", {24'h0, ipiPrio}, 32'hFF);
    check("R1 irqOut", {31'h0, irqOut}, 32'h0);
    check("R1 pulses", {29'h0, dispValid, eoiValid, resendValid}, 32'h0);
  endtask

  task automatic t_reject_rules;
    step(1, 24'h100, 8'h05, 4'd1, 3'd0, 0);
    check("R3 prio>=cur rejected", {31'h0, combReject}, 32'h1);
    check("R3 no state change", pendWord, 32'h0);
    step(0, 0, 0, 0, 3'd3, 32'h8000_0000);
    check("R7 resend pulse", {31'h0, resendValid}, 32'h1);
    check("R7 cur priority", pendWord, 32'h8000_0000);
    step(1, 24'h100, 8'h40, 4'd3, 3'd0, 0);
    check("R4 accepted", {31'h0, combReject}, 32'h0);
    check("R4 loaded", pendWord, 32'h8000_0100);
    check("R2 line high", {31'h0, irqOut}, 32'h1);
    check("R4 no disp from empty", {31'h0, dispValid}, 32'h0);
    step(1, 24'h200, 8'h40, 4'd5, 3'd0, 0);
    check("R3 pending equally favoured rejects", {31'h0, combReject}, 32'h1);
    check("R3 slot kept", pendWord, 32'h8000_0100);
  endtask

  task automatic t_displace;
    step(1, 24'h300, 8'h20, 4'd6, 3'd0, 0);
    check("R4 displacing accepted", {31'h0, combReject}, 32'h0);
    check("R4 disp pulse", {31'h0, dispValid}, 32'h1);
    check("R4 disp source", {8'h0, dispSource}, 32'h100);
    check("R4 disp owner", {28'h0, dispOwner}, 32'h3);
    check("R4 new pending", pendWord, 32'h8000_0300);
  endtask

  task automatic t_accept;
    step(1, 24'h400, 8'h01, 4'd2, 3'd1, 0);
    check("R10 request during op rejected", {31'h0, combReject}, 32'h1);
    check("R5 accept shows word", combWord, 32'h8000_0300);
    check("R5 after accept", pendWord, 32'h2000_0000);
    check("R5 line low", {31'h0, irqOut}, 32'h0);
    step(0, 0, 0, 0, 3'd1, 0);
    check("R5 pending prio back to FF", pendWord, 32'hFF00_0000);
  endtask

  task automatic t_eoi_ipi;
    step(0, 0, 0, 0, 3'd2, 32'h3000_0300);
    check("R9 eoi pulse", {31'h0, eoiValid}, 32'h1);
    check("R9 eoi source", {8'h0, eoiSource}, 32'h300);
    check("R9 resend when empty", {31'h0, resendValid}, 32'h1);
    check("R9 cur priority", pendWord, 32'h3000_0000);
    step(0, 0, 0, 0, 3'd4, 32'h10);
    check("R8 ipi presented", pendWord, 32'h3000_0002);
    check("R8 ipi prio", {24'h0, ipiPrio}, 32'h10);
    check("R8 line high", {31'h0, irqOut}, 32'h1);
    step(1, 24'h500, 8'h08, 4'd7, 3'd0, 0);
    check("R4 displaces ipi", pendWord, 32'h3000_0500);
    check("R4 ipi not reported", {31'h0, dispValid}, 32'h0);
    step(0, 0, 0, 0, 3'd4, 32'h0A);
    check("R8 blocked by favoured pending", pendWord, 32'h3000_0500);
    check("R8 ipi prio stored", {24'h0, ipiPrio}, 32'h0A);
  endtask

  task automatic t_cur_prio;
    step(0, 0, 0, 0, 3'd3, 32'h0500_0000);
    check("R6 dropped", pendWord, 32'h0500_0000);
    check("R6 line low", {31'h0, irqOut}, 32'h0);
    check("R6 disp pulse", {31'h0, dispValid}, 32'h1);
    check("R6 disp source", {8'h0, dispSource}, 32'h500);
    check("R6 disp owner", {28'h0, dispOwner}, 32'h7);
    step(0, 0, 0, 0, 3'd3, 32'h2000_0000);
    check("R7 resend pulse", {31'h0, resendValid}, 32'h1);
    check("R7 ipi presented on resend", pendWord, 32'h2000_0002);
    step(0, 0, 0, 0, 3'd3, 32'h1000_0000);
    check("R6 favoured pending kept", pendWord, 32'h1000_0002);
    check("R6 no disp", {31'h0, dispValid}, 32'h0);
    step(0, 0, 0, 0, 3'd2, 32'h1000_0055);
    check("R9 eoi source", {8'h0, eoiSource}, 32'h55);
    check("R9 no resend while pending", {31'h0, resendValid}, 32'h0);
    check("R9 pending kept", pendWord, 32'h1000_0002);
  endtask

  task automatic t_poll;
    step(0, 0, 0, 0, 3'd0, 32'hFFFF_FFFF);
    check("R2 idle keeps word", pendWord, 32'h1000_0002);
    check("R2 idle keeps ipi", {24'h0, ipiPrio}, 32'h0A);
    check("R2 line", {31'h0, irqOut}, 32'h1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rstN = 1'b1;
        t_reset();
        t_reject_rules();
        t_displace();
        t_accept();
        t_eoi_ipi();
        t_cur_prio();
        t_poll();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule